// File: doc/BRIEF.md
# Accumulator Processor with Micro-Step Sequencer

This block is a small multi-cycle processor built around one accumulator. It has a program counter, an instruction register, a memory address register and a memory data register. Every instruction runs as a chain of single register transfers. Each transfer moves one value between these registers and one shared memory that holds both code and data. A sequencer steps through fetch, decode, operand fetch, execute and write-back as separate states, so the cost of each instruction in cycles is fixed and easy to predict.

The memory is a synchronous array inside the block. While the core is idle or halted, the owning logic reaches this array through a host port: it preloads a program and its data, and reads results back afterwards. A pulse on `run` starts execution at address 0. The core then runs until it meets a stop instruction or an opcode outside the defined set. At that point it parks in a final state and raises `halted`. Only a reset makes the core usable again; the memory contents survive the reset.

Top module: `acc_core`

## Requirements
- R1: After reset, `halted` and `illegal` are 0 and the core stays idle, with memory unchanged, until `run` is sampled high. PC, ACC, IR, AR and DR are cleared, so execution starts at address 0.
- R2: An instruction word is 16 bits. Bits [15:11] hold the opcode and bits [10:0] hold the address. Fetch reads the word at PC and then advances PC by one.
- R3: Opcode 1 loads ACC from memory. Opcode 5 adds a memory word to ACC and opcode 6 subtracts it from ACC, both modulo 2^16.
- R4: Opcode 7 multiplies ACC by a memory word and keeps the low 16 bits of the product.
- R5: Opcode 2 writes ACC to memory at the address field.
- R6: Opcode 15 always continues execution at the address field.
- R7: Opcode 16 jumps to the address field only when ACC, taken as a signed value, is strictly greater than zero. When ACC is zero or negative, execution continues at the next word.
- R8: Opcode 21 stops the core. `halted` then stays high until reset, and the core writes no more memory.
- R9: Any opcode outside {1,2,5,6,7,15,16,21} stops the core, with `illegal` and `halted` both high.
- R10: With MEM_WAIT wait cycles, each memory read takes MEM_WAIT+1 cycles. With the default MEM_WAIT=1, instruction costs are: 10 cycles for load, add, subtract and multiply; 9 for store; 7 for either jump; 6 for stop. One cycle for the start and one for the final check are added to the total.
- R11: While the core is idle or halted, a host write stores `host_wdata` at `host_addr`, and `host_rdata` returns the word at `host_addr` one cycle later. While the core runs, host writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Starts execution when sampled high in the idle state |
| host_we | input | 1 | Host write strobe, honoured only while the core is idle or halted |
| host_addr | input | MEM_AW | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data for the last address presented |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an undefined opcode |

## Verification
Any wrong internal state shows up at the ports as a wrong memory word, a wrong cycle count, or both. A bad ALU result or a bad AR value leaves a wrong value in a store target, which a readback finds once `halted` rises. A wrong branch decision either overwrites a sentinel word or leaves one unwritten. A sequencer that takes an extra or missing micro-step shifts the cycle count of the whole program, and every program's count is checked exactly. A core that fails to stop keeps `halted` low, and the per-run cycle limit catches this within a few thousand cycles.

// File: rtl/acc_core_pkg.sv
// Shared types for the accumulator core: opcode map, sequencer states and
// ALU selections. Assumes a 5-bit opcode field at the top of each word.
package acc_core_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 5'd1,
        OP_STORE = 5'd2,
        OP_ADD   = 5'd5,
        OP_SUB   = 5'd6,
        OP_MUL   = 5'd7,
        OP_JMP   = 5'd15,
        OP_JPOS  = 5'd16,
        OP_STOP  = 5'd21
    } opcode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHK,
        S_F_AR,
        S_F_RD,
        S_F_IR,
        S_F_PC,
        S_O_AR,
        S_O_RD,
        S_EXE,
        S_ST_DR,
        S_ST_WR,
        S_JMP,
        S_END
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_MUL
    } alu_op_e;

endpackage

// File: rtl/acc_mem.sv
// Single-port synchronous word memory shared by code and data.
// Assumes one access per cycle; read data is registered (one-cycle latency).
module acc_mem #(
    parameter int DATA_W = 16,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Array write port; contents are not touched by reset.
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem_q[addr];
    end
endmodule

// File: rtl/acc_alu.sv
// Combinational accumulator ALU. Assumes two's complement words; every result
// is truncated to DATA_W bits.
module acc_alu
    import acc_core_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [2*DATA_W-1:0] prod;

    // Select the result of the requested operation.
    always_comb begin
        prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_MUL: y = prod[DATA_W-1:0];
            default: y = b;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
// Accumulator processor with one state per register transfer.
// Assumes DATA_W = opcode width + address width, MEM_AW <= address width,
// and MEM_WAIT >= 1. The host port reaches memory only while idle or halted.
module acc_core
    import acc_core_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MEM_AW   = 9,
    parameter int MEM_WAIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              host_we,
    input  logic [MEM_AW-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              halted,
    output logic              illegal
);
    localparam int ADDR_W = DATA_W - OP_W;
    localparam int WCNT_W = $clog2(MEM_WAIT + 1);
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(MEM_WAIT);

    state_e              state_q;
    logic [ADDR_W-1:0]   pc_q;
    logic [OP_W-1:0]     ir_q;
    logic [MEM_AW-1:0]   ar_q;
    logic [DATA_W-1:0]   dr_q;
    logic [DATA_W-1:0]   acc_q;
    logic [WCNT_W-1:0]   wait_q;
    logic                active_q;
    logic                illegal_q;

    logic                busy;
    logic                core_we;
    logic                mem_we;
    logic [MEM_AW-1:0]   mem_addr;
    logic [DATA_W-1:0]   mem_wdata;
    logic [DATA_W-1:0]   mem_rdata;
    alu_op_e             alu_op;
    logic [DATA_W-1:0]   alu_y;
    logic                acc_pos;

    // Memory port ownership: core while running, host otherwise.
    always_comb begin
        busy      = (state_q != S_IDLE) && (state_q != S_END);
        core_we   = (state_q == S_ST_WR);
        mem_we    = busy ? core_we : host_we;
        mem_addr  = busy ? ar_q    : host_addr;
        mem_wdata = busy ? dr_q    : host_wdata;
    end

    // ALU selection from the latched opcode and the sign test for jumps.
    always_comb begin
        unique case (ir_q)
            OP_ADD:  alu_op = ALU_ADD;
            OP_SUB:  alu_op = ALU_SUB;
            OP_MUL:  alu_op = ALU_MUL;
            default: alu_op = ALU_PASS;
        endcase
        acc_pos = !acc_q[DATA_W-1] && (acc_q != '0);
    end

    acc_mem #(.DATA_W(DATA_W), .AW(MEM_AW)) i_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    acc_alu #(.DATA_W(DATA_W)) i_alu (
        .op (alu_op),
        .a  (acc_q),
        .b  (dr_q),
        .y  (alu_y)
    );

    // Micro-step sequencer and register transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            pc_q      <= '0;
            ir_q      <= '0;
            ar_q      <= '0;
            dr_q      <= '0;
            acc_q     <= '0;
            wait_q    <= '0;
            active_q  <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: if (run) begin
                    active_q <= 1'b1;
                    state_q  <= S_CHK;
                end
                S_CHK:  state_q <= active_q ? S_F_AR : S_END;
                S_F_AR: begin
                    ar_q    <= pc_q[MEM_AW-1:0];
                    wait_q  <= '0;
                    state_q <= S_F_RD;
                end
                S_F_RD: begin
                    if (wait_q == WAIT_LAST) begin
                        dr_q    <= mem_rdata;
                        state_q <= S_F_IR;
                    end else begin
                        wait_q <= wait_q + WCNT_W'(1);
                    end
                end
                S_F_IR: begin
                    ir_q    <= dr_q[DATA_W-1 -: OP_W];
                    state_q <= S_F_PC;
                end
                S_F_PC: begin
                    pc_q <= pc_q + ADDR_W'(1);
                    unique case (ir_q)
                        OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_MUL:
                            state_q <= S_O_AR;
                        OP_JMP, OP_JPOS:
                            state_q <= S_JMP;
                        OP_STOP: begin
                            active_q <= 1'b0;
                            state_q  <= S_CHK;
                        end
                        default: begin
                            active_q  <= 1'b0;
                            illegal_q <= 1'b1;
                            state_q   <= S_CHK;
                        end
                    endcase
                end
                S_O_AR: begin
                    ar_q    <= dr_q[MEM_AW-1:0];
                    wait_q  <= '0;
                    state_q <= (ir_q == OP_STORE) ? S_ST_DR : S_O_RD;
                end
                S_O_RD: begin
                    if (wait_q == WAIT_LAST) begin
                        dr_q    <= mem_rdata;
                        state_q <= S_EXE;
                    end else begin
                        wait_q <= wait_q + WCNT_W'(1);
                    end
                end
                S_EXE: begin
                    acc_q   <= alu_y;
                    state_q <= S_CHK;
                end
                S_ST_DR: begin
                    dr_q    <= acc_q;
                    state_q <= S_ST_WR;
                end
                S_ST_WR: state_q <= S_CHK;
                S_JMP: begin
                    if (ir_q == OP_JMP || acc_pos) pc_q <= dr_q[ADDR_W-1:0];
                    state_q <= S_CHK;
                end
                default: state_q <= S_END;
            endcase
        end
    end

    assign host_rdata = mem_rdata;
    assign halted     = (state_q == S_END);
    assign illegal    = illegal_q;
endmodule

// File: rtl/acc_core_chk.sv
// Property checker for acc_core, attached by bind. Observes the stop flags,
// core write strobe, sequencer state, PC and the read wait counter.
module acc_core_chk
    import acc_core_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int MEM_WAIT = 1,
    parameter int WCNT_W   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              halted,
    input logic              illegal,
    input logic              core_we,
    input state_e            state,
    input logic [ADDR_W-1:0] pc,
    input logic [WCNT_W-1:0] wcnt
);
    localparam logic [WCNT_W-1:0] WAIT_LAST = WCNT_W'(MEM_WAIT);

    p_idle_until_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !run) |=> (state == S_IDLE));

    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_F_PC) |=> (pc == $past(pc) + ADDR_W'(1)));

    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_no_write_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !core_we);

    p_illegal_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (halted || state == S_CHK));

    p_read_waits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_O_RD && wcnt != WAIT_LAST) |=> (state == S_O_RD));
endmodule

bind acc_core acc_core_chk #(
    .ADDR_W   (ADDR_W),
    .MEM_WAIT (MEM_WAIT),
    .WCNT_W   (WCNT_W)
) i_acc_core_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .halted  (halted),
    .illegal (illegal),
    .core_we (core_we),
    .state   (state_q),
    .pc      (pc_q),
    .wcnt    (wait_q)
);

// File: tb/test_acc_core.sv
`timescale 1ns/100ps
// Directed bench for acc_core: one task per scenario, memory results and
// cycle counts compared against values worked out from the requirements.
module test_acc_core;
    localparam int AW = 9;
    localparam int RUN_LIMIT = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [15:0]   host_rdata;
    logic          halted;
    logic          illegal;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    acc_core i_acc_core (
        .clk(clk), .rst_n(rst_n), .run(run), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .halted(halted), .illegal(illegal)
    );

    function automatic logic [15:0] ins(input int op, input int a);
        return 16'((op << 11) | a);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; run = 1'b0; host_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        @(negedge clk); host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
        @(negedge clk); host_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [15:0] d);
        @(negedge clk); host_addr = AW'(a);
        @(negedge clk); d = host_rdata;
    endtask

    // Start the core and count edges until halted; optionally inject a host write.
    task automatic run_prog(input bit inject, output int cycles);
        @(negedge clk); run = 1'b1;
        @(posedge clk); cycles = 1;
        @(negedge clk); run = 1'b0;
        while (!halted && cycles < RUN_LIMIT) begin
            if (inject && cycles == 20) begin
                host_we = 1'b1; host_addr = AW'(115); host_wdata = 16'hDEAD;
            end else begin
                host_we = 1'b0;
            end
            @(posedge clk); cycles++;
            @(negedge clk);
        end
        host_we = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        poke(300, 16'h0BEE);
        chk("R1 halted after reset", {15'b0, halted}, 16'h0);
        chk("R1 illegal after reset", {15'b0, illegal}, 16'h0);
        repeat (12) @(negedge clk);
        chk("R1 idle without run", {15'b0, halted}, 16'h0);
        peek(300, d);
        chk("R11 host readback", d, 16'h0BEE);
    endtask

    task automatic t_main();
        logic [15:0] d;
        int cyc;
        do_reset();
        poke(0, ins(1, 100));  poke(1, ins(5, 101));  poke(2, ins(2, 110));
        poke(3, ins(1, 102));  poke(4, ins(6, 103));  poke(5, ins(7, 110));
        poke(6, ins(2, 111));  poke(7, ins(1, 104));  poke(8, ins(7, 105));
        poke(9, ins(2, 112));  poke(10, ins(1, 111)); poke(11, ins(6, 112));
        poke(12, ins(2, 113)); poke(13, ins(16, 16)); poke(14, ins(2, 114));
        poke(15, ins(21, 0));  poke(16, ins(6, 106)); poke(17, ins(16, 20));
        poke(18, ins(2, 114)); poke(19, ins(15, 21)); poke(20, ins(2, 115));
        poke(21, ins(21, 0));
        poke(100, 16'd3); poke(101, 16'd4); poke(102, 16'd10); poke(103, 16'd2);
        poke(104, 16'd5); poke(105, 16'd6); poke(106, 16'd100);
        poke(115, 16'h1234);
        run_prog(1'b1, cyc);
        chk("R10 main program cycles", 16'(cyc), 16'd174);
        chk("R8 halted after stop", {15'b0, halted}, 16'h1);
        chk("R9 no illegal on stop", {15'b0, illegal}, 16'h0);
        peek(110, d); chk("R3 add then store", d, 16'd7);
        peek(111, d); chk("R3 sub and mul result", d, 16'd56);
        peek(112, d); chk("R4 product stored", d, 16'd30);
        peek(113, d); chk("R5 stored difference", d, 16'd26);
        peek(114, d); chk("R7 taken jump then untaken on negative", d, 16'hFFB6);
        peek(115, d); chk("R6 jump skipped store, R11 host write ignored", d, 16'h1234);
        peek(14, d);  chk("R5 code word untouched", d, ins(2, 114));
        repeat (5) @(negedge clk);
        chk("R8 halted is sticky", {15'b0, halted}, 16'h1);
        poke(116, 16'h7777);
        peek(116, d); chk("R11 host write while halted", d, 16'h7777);
    endtask

    task automatic t_mul();
        logic [15:0] d;
        int cyc;
        do_reset();
        poke(0, ins(1, 200)); poke(1, ins(7, 200)); poke(2, ins(2, 201));
        poke(3, ins(21, 0)); poke(200, 16'd300);
        run_prog(1'b0, cyc);
        chk("R10 multiply program cycles", 16'(cyc), 16'd37);
        peek(201, d); chk("R4 low half of 300*300", d, 16'h5F90);
    endtask

    task automatic t_jpos_edges();
        logic [15:0] d;
        int cyc;
        do_reset();
        poke(0, ins(1, 210)); poke(1, ins(16, 6)); poke(2, ins(2, 211));
        poke(3, ins(1, 212)); poke(4, ins(16, 6)); poke(5, ins(2, 213));
        poke(6, ins(21, 0));
        poke(210, 16'h0000); poke(211, 16'hAAAA);
        poke(212, 16'h8000); poke(213, 16'hAAAA);
        run_prog(1'b0, cyc);
        chk("R10 conditional program cycles", 16'(cyc), 16'd60);
        peek(211, d); chk("R7 zero not taken", d, 16'h0000);
        peek(213, d); chk("R7 most negative not taken", d, 16'h8000);
    endtask

    task automatic t_illegal();
        logic [15:0] d;
        int cyc;
        do_reset();
        poke(0, ins(1, 220)); poke(1, ins(3, 221)); poke(2, ins(2, 221));
        poke(3, ins(21, 0)); poke(220, 16'h0055); poke(221, 16'hAAAA);
        run_prog(1'b0, cyc);
        chk("R9 illegal program cycles", 16'(cyc), 16'd18);
        chk("R9 illegal flag", {15'b0, illegal}, 16'h1);
        chk("R9 halted on illegal", {15'b0, halted}, 16'h1);
        peek(221, d); chk("R9 no store after illegal", d, 16'hAAAA);
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_main();
        t_mul();
        t_jpos_edges();
        t_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule